// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

An arithmetic and logic unit that works on an internal accumulator register and a second operand taken from a port. On each clock edge where an operation is requested, the block computes the result of the selected operation. It writes that result back to the accumulator, unless the operation is a compare. It also updates a five-bit status register: sign, zero, nibble (auxiliary) carry, even parity and carry. While no operation is requested, both registers hold their values.

The operation set covers the following:
- add and subtract, each with and without an incoming carry;
- increment and decrement;
- AND, OR and XOR;
- compare;
- one's complement;
- four rotates, two of which pass through an external carry bit;
- a load that places the operand into the accumulator.

Results appear on the registered outputs one clock after the request.

Top module: `alu_flags_unit`

## Requirements
- R1: While rst_ni is low, acc_o and flags_o are both 0. The bit order of flags_o is {S,Z,AC,P,CY}: S is bit 4 and CY is bit 0.
- R2: A clock edge with op_valid_i low leaves acc_o and flags_o unchanged, whatever op_i and operand_i carry.
- R3: LOAD (op 0) writes operand_i into the accumulator and leaves flags_o unchanged.
- R4: ADD (op 1) writes A+B and ADC (op 2) writes A+B+carry_i, both modulo 256. CY is the carry out of bit 7.
- R5: SUB (op 3) writes A−B and SBB (op 4) writes A−B−carry_i, both modulo 256. CY is set when a borrow is needed, that is, when the true difference is negative.
- R6: INC (op 5) writes A+1 and DEC (op 6) writes A−1, both wrapping modulo 256. CY keeps its previous value. S, Z, AC and P update.
- R7: AND (op 7), OR (op 8) and XOR (op 9) write the bitwise result. They clear CY and AC.
- R8: CMP (op 10) updates every flag exactly as SUB would, and leaves the accumulator unchanged.
- R9: CPL (op 11) writes the one's complement of A. It updates S, Z and P, and keeps AC and CY.
- R10: RLC (op 12) rotates A left, with bit 7 going to bit 0 and to CY. RRC (op 13) rotates right, with bit 0 going to bit 7 and to CY. RAL (op 14) shifts left with carry_i entering bit 0, and CY takes the old bit 7. RAR (op 15) shifts right with carry_i entering bit 7, and CY takes the old bit 0. All four rotates keep S, Z, AC and P.
- R11: After any operation that updates S, Z and P, the following hold for the new result: S equals its bit 7, Z is 1 exactly when it is zero, and P is 1 exactly when it holds an even number of ones.
- R12: AC is the carry out of bit 3 for ADD, ADC and INC. It is the borrow into bit 4 for SUB, SBB, CMP and DEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Perform op_i on this edge |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Second operand B |
| carry_i | input | 1 | Carry/borrow input for ADC, SBB, RAL, RAR |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | Status {S,Z,AC,P,CY} |

## Verification
The stimulus chain is built so that each arithmetic operation has a distinct role:
- a sum that wraps to zero exercises carry, zero and nibble carry together;
- an ADC whose result depends on carry_i separates it from ADD;
- subtractions that cross zero check the borrow polarity of CY and AC;
- an increment from 0xFF and a decrement from 0x00 show that CY survives wrap-around.

The remaining patterns target the other operations:
- two compares, one equal and one lower, confirm that the accumulator holds its value while the flags move;
- logical operations that follow a set carry prove that CY is cleared;
- the rotate chain alternates carry_i, so the through-carry forms can be told apart from the plain rotates.

Directed steps then apply operation codes with op_valid_i low, and assert reset mid-run.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [3:0] {
    OP_LOAD = 4'd0,  OP_ADD = 4'd1,  OP_ADC = 4'd2,  OP_SUB = 4'd3,
    OP_SBB  = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_AND = 4'd7,
    OP_OR   = 4'd8,  OP_XOR = 4'd9,  OP_CMP = 4'd10, OP_CPL = 4'd11,
    OP_RLC  = 4'd12, OP_RRC = 4'd13, OP_RAL = 4'd14, OP_RAR = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,   // carry for add, borrow for subtract
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,  // carry for add, borrow for subtract
  output logic              nib_o    // same sense, at nibble boundary
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [DATA_W-1:0] b_x;
  logic              c_in;
  logic [NIB_W:0]    lo;
  logic [HI_W:0]     hi;

  // a - b - bin == a + ~b + !bin
  assign b_x  = sub_i ? ~b_i : b_i;
  assign c_in = cin_i ^ sub_i;
  assign lo   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_x[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_in};
  assign hi   = {1'b0, a_i[DATA_W-1:NIB_W]} + {1'b0, b_x[DATA_W-1:NIB_W]}
              + {{HI_W{1'b0}}, lo[NIB_W]};

  assign sum_o  = {hi[HI_W-1:0], lo[NIB_W-1:0]};
  assign cout_o = hi[HI_W] ^ sub_i;
  assign nib_o  = lo[NIB_W] ^ sub_i;
endmodule

// File: rtl/alu_logic_rot.sv
module alu_logic_rot
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              rot_cy_o
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res_o    = a_i;
    rot_cy_o = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RLC: begin res_o = {a_i[MSB-1:0], a_i[MSB]}; rot_cy_o = a_i[MSB]; end
      OP_RRC: begin res_o = {a_i[0], a_i[MSB:1]};     rot_cy_o = a_i[0];   end
      OP_RAL: begin res_o = {a_i[MSB-1:0], carry_i};  rot_cy_o = a_i[MSB]; end
      OP_RAR: begin res_o = {carry_i, a_i[MSB:1]};    rot_cy_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              s_o,
  output logic              z_o,
  output logic              p_o
);
  assign s_o = res_i[DATA_W-1];
  assign z_o = (res_i == '0);
  assign p_o = ~^res_i;
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [4:0]        flags_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] acc_q, ar_b, ar_sum, lr_res, res;
  logic              ar_cin, ar_sub, ar_cout, ar_nib, rot_cy;
  logic              st_s, st_z, st_p;
  alu_flags_t        flg_q, flg_d;
  logic              wr_acc;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ar_b   = operand_i;
    ar_cin = 1'b0;
    ar_sub = 1'b0;
    unique case (op)
      OP_ADC:         ar_cin = carry_i;
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBB: begin   ar_sub = 1'b1; ar_cin = carry_i; end
      OP_INC: begin   ar_b = '0; ar_cin = 1'b1; end
      OP_DEC: begin   ar_b = '0; ar_cin = 1'b1; ar_sub = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
    .a_i(acc_q), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
    .sum_o(ar_sum), .cout_o(ar_cout), .nib_o(ar_nib)
  );

  alu_logic_rot #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(acc_q), .b_i(operand_i), .carry_i(carry_i),
    .res_o(lr_res), .rot_cy_o(rot_cy)
  );

  always_comb begin
    unique case (op)
      OP_LOAD: res = operand_i;
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC, OP_CMP: res = ar_sum;
      default: res = lr_res;
    endcase
  end

  alu_status #(.DATA_W(DATA_W)) u_status (
    .res_i(res), .s_o(st_s), .z_o(st_z), .p_o(st_p)
  );

  always_comb begin
    flg_d = flg_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        flg_d = '{s: st_s, z: st_z, ac: ar_nib, p: st_p, cy: ar_cout};
      end
      OP_INC, OP_DEC: begin
        flg_d = '{s: st_s, z: st_z, ac: ar_nib, p: st_p, cy: flg_q.cy};
      end
      OP_AND, OP_OR, OP_XOR: begin
        flg_d = '{s: st_s, z: st_z, ac: 1'b0, p: st_p, cy: 1'b0};
      end
      OP_CPL: begin
        flg_d.s = st_s;
        flg_d.z = st_z;
        flg_d.p = st_p;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: flg_d.cy = rot_cy;
      default: ;
    endcase
  end

  assign wr_acc = op_valid_i && (op != OP_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_acc)     acc_q <= res;
      if (op_valid_i) flg_q <= flg_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flg_q;

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(acc_o) && $stable(flags_o));

  a_r8_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op == OP_CMP |=> acc_o == $past(acc_o));

  a_r6_incdec_keeps_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op == OP_INC || op == OP_DEC) |=> flags_o[0] == $past(flags_o[0]));

  a_r7_logic_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op == OP_AND || op == OP_OR || op == OP_XOR) |=> flags_o[0] == 1'b0 && flags_o[2] == 1'b0);

  a_r3_load_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op == OP_LOAD |=> $stable(flags_o));

  a_r10_rot_keeps_szap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i[3:2] == 2'b11 |=> flags_o[4:1] == $past(flags_o[4:1]));

  a_r11_flags_track_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op != OP_LOAD && op != OP_CMP && op_i[3:2] != 2'b11
      |=> flags_o[4] == acc_o[DATA_W-1] && flags_o[3] == (acc_o == '0) && flags_o[1] == ~^acc_o);
endmodule

// File: tb/alu_flags_unit_bench.sv
module alu_flags_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic       carry = 1'b0;
  logic [7:0] acc;
  logic [4:0] flags;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .operand_i(operand), .carry_i(carry), .acc_o(acc), .flags_o(flags)
  );

  // {op, operand, carry_i, expected acc, expected flags {S,Z,AC,P,CY}}
  localparam logic [25:0] VEC [N_VEC] = '{
    {4'd0,  8'h3A, 1'b0, 8'h3A, 5'b00000},  // R3 load
    {4'd1,  8'hC6, 1'b0, 8'h00, 5'b01111},  // R4 R12 wrap to zero
    {4'd0,  8'h0F, 1'b0, 8'h0F, 5'b01111},  // R3 flags kept
    {4'd2,  8'h01, 1'b1, 8'h11, 5'b00110},  // R4 adc uses carry_i
    {4'd3,  8'h12, 1'b0, 8'hFF, 5'b10111},  // R5 borrow
    {4'd4,  8'h0F, 1'b1, 8'hEF, 5'b10100},  // R5 R12 sbb
    {4'd5,  8'h00, 1'b0, 8'hF0, 5'b10110},  // R6 inc
    {4'd10, 8'hF0, 1'b0, 8'hF0, 5'b01010},  // R8 cmp equal
    {4'd10, 8'hF1, 1'b0, 8'hF0, 5'b10111},  // R8 cmp lower
    {4'd6,  8'h00, 1'b0, 8'hEF, 5'b10101},  // R6 dec keeps cy=1
    {4'd7,  8'h0F, 1'b0, 8'h0F, 5'b00010},  // R7 and clears cy
    {4'd8,  8'h80, 1'b0, 8'h8F, 5'b10000},  // R7 R11 odd parity
    {4'd9,  8'h8F, 1'b0, 8'h00, 5'b01010},  // R7 xor to zero
    {4'd6,  8'h00, 1'b0, 8'hFF, 5'b10110},  // R6 dec from 00
    {4'd11, 8'h00, 1'b0, 8'h00, 5'b01110},  // R9 cpl keeps ac, cy
    {4'd0,  8'h81, 1'b0, 8'h81, 5'b01110},  // R3
    {4'd12, 8'h00, 1'b0, 8'h03, 5'b01111},  // R10 rlc
    {4'd13, 8'h00, 1'b0, 8'h81, 5'b01111},  // R10 rrc
    {4'd14, 8'h00, 1'b0, 8'h02, 5'b01111},  // R10 ral carry_i=0
    {4'd15, 8'h00, 1'b1, 8'h81, 5'b01110},  // R10 rar carry_i=1
    {4'd14, 8'h00, 1'b1, 8'h03, 5'b01111},  // R10 ral carry_i=1
    {4'd1,  8'h7D, 1'b0, 8'h80, 5'b10100},  // R4 R12 nibble carry
    {4'd5,  8'h00, 1'b0, 8'h81, 5'b10010},  // R6 R11
    {4'd0,  8'hFF, 1'b0, 8'hFF, 5'b10010},  // R3
    {4'd5,  8'h00, 1'b0, 8'h00, 5'b01110}   // R6 inc wrap keeps cy=0
  };

  task automatic check(input string req, input logic [7:0] exp_acc, input logic [4:0] exp_fl);
    n_vec++;
    if (acc !== exp_acc || flags !== exp_fl) begin
      n_bad++;
      $display("FAIL %s: acc=%h flags=%b, expected acc=%h flags=%b", req, acc, flags, exp_acc, exp_fl);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic [7:0] b, input logic c);
    @(negedge clk);
    op_valid = v; op = o; operand = b; carry = c;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 8'h00, 5'b00000);
    rst_n = 1'b1;
    for (int i = 0; i < N_VEC; i++) begin
      step(1'b1, VEC[i][25:22], VEC[i][21:14], VEC[i][13]);
      check($sformatf("vector %0d", i), VEC[i][12:5], VEC[i][4:0]);
    end
    // R2: requests with op_valid low change nothing
    step(1'b0, 4'd1, 8'h55, 1'b1);
    check("R2", 8'h00, 5'b01110);
    step(1'b0, 4'd0, 8'hA5, 1'b0);
    check("R2", 8'h00, 5'b01110);
    step(1'b0, 4'd12, 8'h00, 1'b1);
    check("R2", 8'h00, 5'b01110);
    // R1: reset mid-run
    step(1'b1, 4'd0, 8'h5A, 1'b0);
    check("R3", 8'h5A, 5'b01110);
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", 8'h00, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 4'd3, 8'h01, 1'b0);   // 00-01: FF, borrow in both places
    check("R5", 8'hFF, 5'b10111);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule